// File: doc/BRIEF.md
# Complementary Output Short Protection Controller

This block protects the high-current outputs of a motor-control timer. It watches three pairs of complementary PWM outputs. If both pins of an armed pair drive the active level at once, it pulls the output enables of all six high-current pins low, so the pads go to high impedance. A polarity input selects whether the active level is high or low. A pair is only compared while the pin multiplexer routes that pair to the timer or to general-purpose output. Under any other pin function the pair's levels are ignored.

Three active-low external emergency requests also force the six high-current pins to high impedance. A fourth request acts only on the channel-0 timer pins. Each trigger source sets a sticky flag. The matching output enables stay low until that flag is cleared and the triggering condition is gone. When no condition is present, every output enable is high and the pads follow the timer.

Top module: `pwm_short_guard`

## Requirements
- R1: While rst_ni is low, every bit of flag_o, hc_oe_o and ch0_oe_o is 0, and the captured pair enables are cleared. From the first clock edge after reset is released, the output enables follow R6 to R10.
- R2: pol_hi_i = 0 makes low the active level and pol_hi_i = 1 makes high the active level. A pair whose two pins are both at the active level is a short.
- R3: Pair p is formed by pwm_i[2p] and pwm_i[2p+1]. Pair 0 is channel 3 B/D, pair 1 is channel 4 A/C and pair 2 is channel 4 B/D. A short on pair p sets flag_o[p].
- R4: A pair whose func_ok_i bit is 0 never counts as a short, whatever its levels are.
- R5: cmp_en_i is captured on each clock edge, and a pair is compared only while its captured bit is 1. A change therefore takes effect from the cycle after the edge that samples it.
- R6: A short drops all of hc_oe_o combinationally, in the same cycle it appears. The matching flag is set at the next edge.
- R7: Each request in hc_req_ni is active low and passes through a two-flop synchronizer. It counts only after it has been sampled low on two consecutive edges. hc_oe_o then drops after the second edge following the first low sample, and flag_o[3+i] is set one edge later. A low that is sampled on only one edge has no effect.
- R8: ch0_req_ni is qualified the same way as R7. It drops only ch0_oe_o and sets flag_o[6]. It leaves hc_oe_o unchanged.
- R9: A request input held high, as the pull-up leaves an undriven pin, never triggers.
- R10: A flag stays set until its clr_i bit is 1 on an edge while its trigger is absent. A clear is ignored while the trigger is still present. Output enables return high once every relevant flag is clear and no trigger is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 6 | Timer output levels; pair p uses bits 2p and 2p+1 |
| pol_hi_i | input | 1 | Active level select: 1 = high, 0 = low |
| func_ok_i | input | 3 | Per pair: pins routed to the timer or general-purpose output |
| cmp_en_i | input | 3 | Per pair: compare enable |
| hc_req_ni | input | 3 | External requests for the high-current pins, active low |
| ch0_req_ni | input | 1 | External request for the channel-0 pins, active low |
| clr_i | input | 7 | Clear strobes, in the same bit layout as flag_o |
| hc_oe_o | output | 6 | Output enables of the high-current pins |
| ch0_oe_o | output | 4 | Output enables of the channel-0 pins |
| flag_o | output | 7 | Sticky flags: [2:0] pair shorts, [5:3] hc requests, [6] ch0 request |

## Verification
A short reaches the enables in the same cycle and the flags one edge later. A request reaches the enables two edges after its first low sample and the flags three edges after it. The captured compare enables act one edge after they are driven. The bench drives every input on the falling clock edge and compares all outputs shortly afterwards, before the next rising edge. It advances its own reference state only after that rising edge, so each expected value carries exactly the register delays listed above.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam int unsigned N_PAIRS  = 3;
  localparam int unsigned N_HC_REQ = 3;
  localparam int unsigned N_FLAGS  = N_PAIRS + N_HC_REQ + 1;
  localparam int unsigned HC_PINS  = 2 * N_PAIRS;
  // flag layout: shorts, then hc requests, then ch0 request
  localparam int unsigned F_REQ0 = N_PAIRS;
  localparam int unsigned F_CH0  = N_PAIRS + N_HC_REQ;
endpackage

// File: rtl/psg_req_sync.sv
module psg_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic qual_o
);
  // STAGES sync flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], req_ni};
  end

  assign qual_o = ~sh_q[STAGES] & ~sh_q[STAGES-1];

  assert_req_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_o |-> ($past(!req_ni, STAGES) && $past(!req_ni, STAGES + 1)));
endmodule

// File: rtl/psg_pair_cmp.sv
module psg_pair_cmp (
  input  logic a_i,
  input  logic b_i,
  input  logic pol_hi_i,
  input  logic func_ok_i,
  input  logic en_i,
  output logic hit_o
);
  logic both_act;
  assign both_act = (a_i == pol_hi_i) && (b_i == pol_hi_i);
  assign hit_o    = en_i & func_ok_i & both_act;
endmodule

// File: rtl/psg_flag_bank.sv
module psg_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  // live trigger wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_o[i]);
    assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
  end
endmodule

// File: rtl/pwm_short_guard.sv
module pwm_short_guard
  import psg_pkg::*;
#(
  parameter int unsigned CH0_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [HC_PINS-1:0]  pwm_i,
  input  logic                pol_hi_i,
  input  logic [N_PAIRS-1:0]  func_ok_i,
  input  logic [N_PAIRS-1:0]  cmp_en_i,
  input  logic [N_HC_REQ-1:0] hc_req_ni,
  input  logic                ch0_req_ni,
  input  logic [N_FLAGS-1:0]  clr_i,
  output logic [HC_PINS-1:0]  hc_oe_o,
  output logic [CH0_PINS-1:0] ch0_oe_o,
  output logic [N_FLAGS-1:0]  flag_o
);
  logic [N_PAIRS-1:0]  cen_q;
  logic                run_q;
  logic [N_PAIRS-1:0]  short_hit;
  logic [N_HC_REQ-1:0] hc_qual;
  logic                ch0_qual;
  logic [N_FLAGS-1:0]  set_vec;
  logic                hc_hiz, ch0_hiz;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_q <= '0;
      run_q <= 1'b0;
    end else begin
      cen_q <= cmp_en_i;
      run_q <= 1'b1;
    end
  end

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    psg_pair_cmp i_cmp (
      .a_i       (pwm_i[2*p]),
      .b_i       (pwm_i[2*p+1]),
      .pol_hi_i  (pol_hi_i),
      .func_ok_i (func_ok_i[p]),
      .en_i      (cen_q[p]),
      .hit_o     (short_hit[p])
    );
  end

  for (genvar r = 0; r < N_HC_REQ; r++) begin : g_req
    psg_req_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_ni (hc_req_ni[r]),
      .qual_o (hc_qual[r])
    );
  end

  psg_req_sync #(.STAGES(SYNC_STAGES)) i_ch0_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_ni (ch0_req_ni),
    .qual_o (ch0_qual)
  );

  assign set_vec = {ch0_qual, hc_qual, short_hit};

  psg_flag_bank #(.N(N_FLAGS)) i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_i),
    .flag_o (flag_o)
  );

  // enables fall combinationally on a live trigger
  assign hc_hiz   = (|flag_o[F_CH0-1:0]) | (|short_hit) | (|hc_qual);
  assign ch0_hiz  = flag_o[F_CH0] | ch0_qual;
  assign hc_oe_o  = {HC_PINS{run_q & ~hc_hiz}};
  assign ch0_oe_o = {CH0_PINS{run_q & ~ch0_hiz}};

  assert_short_hiz_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|short_hit) |-> (hc_oe_o == '0));
  assert_ch0_hiz_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch0_qual |-> (ch0_oe_o == '0));
  assert_req_hiz_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hc_qual) |-> (hc_oe_o == '0));
endmodule

// File: tb/test_pwm_short_guard.sv
module test_pwm_short_guard;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [5:0] pwm_i = '0;
  logic       pol_hi_i = 1'b0;
  logic [2:0] func_ok_i = '1;
  logic [2:0] cmp_en_i = '0;
  logic [2:0] hc_req_ni = '1;
  logic       ch0_req_ni = 1'b1;
  logic [6:0] clr_i = '0;
  logic [5:0] hc_oe_o;
  logic [3:0] ch0_oe_o;
  logic [6:0] flag_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit       m_run;
  bit [2:0] m_cen;
  bit [6:0] m_flag;
  bit [3:0] m_s1, m_s2, m_s3;

  always #5 clk_i = ~clk_i;

  pwm_short_guard i_pwm_short_guard (.*);

  function automatic bit [2:0] exp_det();
    bit [2:0] d;
    for (int p = 0; p < 3; p++)
      d[p] = m_cen[p] & func_ok_i[p] & (pwm_i[2*p] == pol_hi_i) & (pwm_i[2*p+1] == pol_hi_i);
    return d;
  endfunction

  function automatic bit [3:0] exp_qual();
    return ~m_s2 & ~m_s3;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_run = 0; m_cen = '0; m_flag = '0; m_s1 = '1; m_s2 = '1; m_s3 = '1;
  endtask

  task automatic step(string tag);
    bit [2:0] d; bit [3:0] q; bit hz, cz;
    #1;
    d = exp_det(); q = exp_qual();
    hz = (|m_flag[5:0]) | (|d) | (|q[2:0]);
    cz = m_flag[6] | q[3];
    chk({tag, " hc_oe"}, 32'(hc_oe_o), 32'({6{m_run & ~hz}}));
    chk({tag, " ch0_oe"}, 32'(ch0_oe_o), 32'({4{m_run & ~cz}}));
    chk({tag, " flag"}, 32'(flag_o), 32'(m_flag));
    @(posedge clk_i);
    m_flag = {q, d} | (m_flag & ~clr_i);
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = {ch0_req_ni, hc_req_ni};
    m_cen = cmp_en_i; m_run = 1;
    @(negedge clk_i);
  endtask

  task automatic quiet(string tag, int n);
    pwm_i = pol_hi_i ? 6'b000000 : 6'b111111;
    hc_req_ni = '1; ch0_req_ni = 1'b1;
    for (int i = 0; i < n; i++) begin
      clr_i = '1; step(tag);
    end
    clr_i = '0;
  endtask

  initial begin
    int hold [4];
    void'($urandom(32'd20240611));
    model_reset();
    #2 rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    cmp_en_i = '1; pwm_i = '0;
    #1;
    chk("R1 reset hc_oe", 32'(hc_oe_o), 0);
    chk("R1 reset ch0_oe", 32'(ch0_oe_o), 0);
    chk("R1 reset flag", 32'(flag_o), 0);
    rst_ni = 1'b1;
    // R5: enables captured at first edge, so no short yet; then short on all pairs
    step("R5 first cycle");
    step("R5 R2 low-active short");
    quiet("R10 clear", 2);
    pol_hi_i = 1'b1; pwm_i = 6'b000011;
    step("R2 high-active pair0");
    step("R2 flag pair0");
    quiet("R10 clear", 2);
    pwm_i = 6'b001100;
    step("R3 pair1 mapping");
    step("R3 pair1 flag");
    quiet("R10 clear", 2);
    func_ok_i = 3'b101; pwm_i = 6'b001100;
    step("R4 pair1 function off");
    step("R4 no flag");
    func_ok_i = '1;
    cmp_en_i = 3'b110; pwm_i = 6'b000011;
    step("R5 enable still set");
    step("R5 enable cleared");
    cmp_en_i = '1; pwm_i = 6'b110000;
    step("R10 short live");
    clr_i = '1;
    step("R10 clear while live");
    step("R10 clear while live 2");
    pwm_i = 6'b000000;
    step("R10 clear accepted");
    clr_i = '0;
    step("R10 enables restored");
    hc_req_ni[0] = 1'b0; step("R7 single low");
    hc_req_ni[0] = 1'b1;
    for (int i = 0; i < 4; i++) step("R7 single low no effect");
    hc_req_ni[1] = 1'b0;
    for (int i = 0; i < 4; i++) step("R7 held low");
    quiet("R10 clear", 4);
    ch0_req_ni = 1'b0;
    for (int i = 0; i < 4; i++) step("R8 ch0 only");
    quiet("R10 clear", 4);
    for (int i = 0; i < 8; i++) step("R9 idle high");
    // random phase
    foreach (hold[k]) hold[k] = 0;
    for (int n = 0; n < 3000; n++) begin
      if (n % 200 == 0) pol_hi_i = 1'($urandom);
      pwm_i = 6'($urandom);
      if ($urandom_range(3) != 0) pwm_i = pol_hi_i ? (pwm_i & 6'b010101) : (pwm_i | 6'b101010);
      func_ok_i = 3'($urandom) | 3'($urandom);
      if ($urandom_range(15) == 0) cmp_en_i = 3'($urandom);
      for (int k = 0; k < 4; k++) begin
        if (hold[k] == 0 && $urandom_range(40) == 0) hold[k] = $urandom_range(1, 4);
        if (hold[k] > 0) hold[k]--;
      end
      hc_req_ni = {hold[2] == 0, hold[1] == 0, hold[0] == 0};
      ch0_req_ni = (hold[3] == 0);
      clr_i = ($urandom_range(3) == 0) ? 7'($urandom) : '0;
      step("R2 R4 R6 R7 R8 R10 random");
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule